// File: doc/BRIEF.md
# Bus Cycle Status Encoder

This block drives the three-bit status code that tells an external command generator what kind of bus cycle is under way, so that the generator can produce the memory and I/O strobes. It is given the current bus phase, a pending cycle request with its cycle kind, the READY input and a bus-grant input. From these it places the status code on its output with the right activation and deactivation timing.

A code goes out in the idle phase or in T4 when a request is pending. It is then held through T1 and T2, and it goes back to the passive code in T3 or in a wait state once READY is high. Two single-cycle pulses mark where the status leaves the passive code (cycle start) and where it returns to it (cycle end). A downstream decoder can use them without watching the code itself. While another master holds the bus grant, the status is forced to the passive code and a float indication is raised.

Top module: `bus_status_encoder`

## Requirements
- R1: The status code values are: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. A launched cycle shows its requested kind code on `stat_o` unchanged.
- R2: Phase codes on `phase_i` are 0 idle (TI), 1 T1, 2 T2, 3 T3, 4 wait (TW), 5 T4. Codes 6 and 7 give passive status and drop any open cycle. In phase 0 or 5, when `pend_i` is high and `kind_i` is not 111, `stat_o` shows `kind_i` in that same cycle and the kind is captured.
- R3: In T1 and T2, `stat_o` shows the captured code. Changes on `kind_i` and `pend_i` during these phases have no effect.
- R4: In T3 or TW, `stat_o` keeps the captured code while `ready_i` is low. It is 111 in the first T3 or TW cycle with `ready_i` high, and that cycle closes the cycle.
- R5: With no pending request, or with a request of kind 111, `stat_o` stays 111 and `start_o` stays low.
- R6: `start_o` is high for exactly the cycle in which `stat_o` is not 111 and was 111 in the previous cycle.
- R7: `end_o` is high for exactly the cycle in which `stat_o` is 111 and was not 111 in the previous cycle.
- R8: While `grant_i` is high, `stat_o` is 111, `float_o` is high, both pulses are low, and an open cycle is abandoned. Its later T1 and T2 show 111.
- R9: While `rst` is high, `stat_o` is 111, `float_o` is low and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_i | input | 3 | Current bus phase code |
| pend_i | input | 1 | A cycle request is pending |
| kind_i | input | 3 | Status code of the requested cycle |
| ready_i | input | 1 | Memory or I/O ready |
| grant_i | input | 1 | Bus granted to another master |
| stat_o | output | 3 | Status code |
| float_o | output | 1 | Status lines floated at logic one |
| start_o | output | 1 | Cycle-start pulse |
| end_o | output | 1 | Cycle-end pulse |

## Verification
The status code and both pulses follow the inputs of the same cycle. Only the captured kind, the open-cycle flag and the previous status are registered, and these affect outputs from the cycle after the edge. The driver applies inputs just after a rising edge and queues the expected values for that same cycle. The monitor compares at the following falling edge, so every result is checked in the cycle it is due, and a state change is checked one cycle after the phase that caused it. The sequences cover wait states, back-to-back cycles of every kind, kind changes that must be ignored, and a grant that interrupts an open cycle.

// File: rtl/bus_status_pkg.sv
package bus_status_pkg;

    localparam int STAT_W  = 3;
    localparam int PHASE_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_INTA  = 3'b000,
        ST_IORD  = 3'b001,
        ST_IOWR  = 3'b010,
        ST_HALT  = 3'b011,
        ST_FETCH = 3'b100,
        ST_MEMRD = 3'b101,
        ST_MEMWR = 3'b110,
        ST_IDLE  = 3'b111
    } stat_t;

    typedef enum logic [PHASE_W-1:0] {
        PH_TI = 3'd0,
        PH_T1 = 3'd1,
        PH_T2 = 3'd2,
        PH_T3 = 3'd3,
        PH_TW = 3'd4,
        PH_T4 = 3'd5
    } phase_t;

    typedef struct packed {
        logic  open;
        stat_t code;
    } track_t;

    function automatic logic is_launch_phase(input logic [PHASE_W-1:0] ph);
        return (ph == PH_TI) || (ph == PH_T4);
    endfunction

    function automatic logic is_hold_phase(input logic [PHASE_W-1:0] ph);
        return (ph == PH_T1) || (ph == PH_T2);
    endfunction

    function automatic logic is_drain_phase(input logic [PHASE_W-1:0] ph);
        return (ph == PH_T3) || (ph == PH_TW);
    endfunction

    function automatic logic wants_launch(input logic pend, input logic [STAT_W-1:0] kind);
        return pend && (kind != ST_IDLE);
    endfunction

endpackage

// File: rtl/bst_cycle_track.sv
module bst_cycle_track
    import bus_status_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               pend_i,
    input  logic [STAT_W-1:0]  kind_i,
    input  logic               ready_i,
    input  logic               grant_i,
    output track_t             trk_o
);
    track_t trk_q, trk_d;

    always_comb begin
        trk_d = trk_q;
        if (grant_i) begin
            trk_d.open = 1'b0;
        end else if (is_launch_phase(phase_i)) begin
            trk_d.open = wants_launch(pend_i, kind_i);
            if (wants_launch(pend_i, kind_i))
                trk_d.code = stat_t'(kind_i);
        end else if (is_drain_phase(phase_i)) begin
            if (ready_i)
                trk_d.open = 1'b0;
        end else if (!is_hold_phase(phase_i)) begin
            trk_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q.open <= 1'b0;
            trk_q.code <= ST_IDLE;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign trk_o = trk_q;
endmodule

// File: rtl/bst_code_select.sv
module bst_code_select
    import bus_status_pkg::*;
(
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               pend_i,
    input  logic [STAT_W-1:0]  kind_i,
    input  logic               ready_i,
    input  logic               grant_i,
    input  track_t             trk_i,
    output stat_t              stat_o
);
    always_comb begin
        stat_o = ST_IDLE;
        if (!rst && !grant_i) begin
            if (is_launch_phase(phase_i)) begin
                if (wants_launch(pend_i, kind_i))
                    stat_o = stat_t'(kind_i);
            end else if (is_hold_phase(phase_i)) begin
                if (trk_i.open)
                    stat_o = trk_i.code;
            end else if (is_drain_phase(phase_i)) begin
                if (trk_i.open && !ready_i)
                    stat_o = trk_i.code;
            end
        end
    end
endmodule

// File: rtl/bst_transition.sv
module bst_transition
    import bus_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  grant_i,
    input  stat_t stat_i,
    output logic  start_o,
    output logic  end_o
);
    stat_t prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= ST_IDLE;
        else
            prev_q <= stat_i;
    end

    always_comb begin
        start_o = 1'b0;
        end_o   = 1'b0;
        if (!rst && !grant_i) begin
            start_o = (prev_q == ST_IDLE) && (stat_i != ST_IDLE);
            end_o   = (prev_q != ST_IDLE) && (stat_i == ST_IDLE);
        end
    end
endmodule

// File: rtl/bus_status_encoder.sv
module bus_status_encoder
    import bus_status_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               pend_i,
    input  logic [STAT_W-1:0]  kind_i,
    input  logic               ready_i,
    input  logic               grant_i,
    output logic [STAT_W-1:0]  stat_o,
    output logic               float_o,
    output logic               start_o,
    output logic               end_o
);
    track_t trk;
    stat_t  stat;

    bst_cycle_track u_track (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase_i),
        .pend_i  (pend_i),
        .kind_i  (kind_i),
        .ready_i (ready_i),
        .grant_i (grant_i),
        .trk_o   (trk)
    );

    bst_code_select u_select (
        .rst     (rst),
        .phase_i (phase_i),
        .pend_i  (pend_i),
        .kind_i  (kind_i),
        .ready_i (ready_i),
        .grant_i (grant_i),
        .trk_i   (trk),
        .stat_o  (stat)
    );

    bst_transition u_trans (
        .clk     (clk),
        .rst     (rst),
        .grant_i (grant_i),
        .stat_i  (stat),
        .start_o (start_o),
        .end_o   (end_o)
    );

    assign stat_o  = stat;
    assign float_o = grant_i && !rst;

    // R8: grant forces passive code with no pulses
    p_grant_idle_r8: assert property (@(posedge clk) disable iff (rst)
        grant_i |-> (stat_o == ST_IDLE) && !start_o && !end_o);

    // R4: ready in T3 closes the cycle with passive status
    p_t3_ready_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_T3 && ready_i) |-> (stat_o == ST_IDLE));

    // R3: code held from T1 into T2
    p_hold_t1_t2_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_T1 && !grant_i) ##1 (phase_i == PH_T2 && !grant_i)
        |-> $stable(stat_o));

    // R6: start pulse lasts one cycle
    p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    // R7: start and end never together
    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(start_o && end_o));

    // R5: passive request kind never produces a start
    p_idle_kind_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_TI && kind_i == ST_IDLE) |-> !start_o);
endmodule

// File: tb/test_bus_status_encoder.sv
module test_bus_status_encoder;
    import bus_status_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic [2:0] phase;
    logic       pend;
    logic [2:0] kind;
    logic       ready;
    logic       grant;
    logic [2:0] stat;
    logic       flt, st_p, en_p;

    bus_status_encoder i_bus_status_encoder (
        .clk(clk), .rst(rst), .phase_i(phase), .pend_i(pend), .kind_i(kind),
        .ready_i(ready), .grant_i(grant), .stat_o(stat), .float_o(flt),
        .start_o(st_p), .end_o(en_p)
    );

    typedef struct {
        logic [2:0] st;
        logic       s;
        logic       e;
        logic       f;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done = 0;

    logic       m_open;
    logic [2:0] m_code;
    logic [2:0] m_prev;

    task automatic step(input logic [2:0] ph, input logic p, input logic [2:0] k,
                        input logic r, input logic g, input string tag);
        exp_t x;
        logic [2:0] s;
        logic l;
        @(posedge clk);
        #1;
        phase = ph; pend = p; kind = k; ready = r; grant = g;
        l = p && (k != 3'b111);
        s = 3'b111;
        if (!g) begin
            if (ph == 3'd0 || ph == 3'd5) s = l ? k : 3'b111;
            else if (ph == 3'd1 || ph == 3'd2) s = m_open ? m_code : 3'b111;
            else if (ph == 3'd3 || ph == 3'd4) s = (m_open && !r) ? m_code : 3'b111;
        end
        x.st = s;
        x.s = !g && (m_prev == 3'b111) && (s != 3'b111);
        x.e = !g && (m_prev != 3'b111) && (s == 3'b111);
        x.f = g;
        x.tag = tag;
        q.push_back(x);
        if (g) m_open = 1'b0;
        else if (ph == 3'd0 || ph == 3'd5) begin
            m_open = l;
            if (l) m_code = k;
        end else if (ph == 3'd3 || ph == 3'd4) begin
            if (r) m_open = 1'b0;
        end else if (!(ph == 3'd1 || ph == 3'd2)) m_open = 1'b0;
        m_prev = s;
    endtask

    initial begin : monitor
        exp_t x;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                x = q.pop_front();
                checks++;
                if (stat !== x.st || st_p !== x.s || en_p !== x.e || flt !== x.f) begin
                    errors++;
                    $display("FAIL %s: stat=%b start=%b end=%b float=%b expected stat=%b start=%b end=%b float=%b",
                             x.tag, stat, st_p, en_p, flt, x.st, x.s, x.e, x.f);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        rst = 1'b1; phase = 3'd0; pend = 1'b1; kind = 3'b101; ready = 1'b1; grant = 1'b0;
        m_open = 1'b0; m_code = 3'b111; m_prev = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (stat !== 3'b111 || flt !== 1'b0 || st_p !== 1'b0 || en_p !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: stat=%b float=%b start=%b end=%b expected 111 0 0 0",
                     stat, flt, st_p, en_p);
        end
        pend = 1'b0;
        @(posedge clk);
        #1 rst = 1'b0;

        // R5: idle, nothing pending or passive kind
        step(3'd0, 1'b0, 3'b101, 1'b1, 1'b0, "R5 idle");
        step(3'd0, 1'b0, 3'b000, 1'b1, 1'b0, "R5 idle");
        step(3'd0, 1'b1, 3'b111, 1'b1, 1'b0, "R5 passive kind");
        step(3'd5, 1'b0, 3'b110, 1'b1, 1'b0, "R5 T4 no request");

        // R2 launch from idle, R3 hold with kind changes ignored, R4/R7 close
        step(3'd0, 1'b1, 3'b101, 1'b1, 1'b0, "R2 R6 launch");
        step(3'd1, 1'b1, 3'b000, 1'b1, 1'b0, "R3 T1 hold");
        step(3'd2, 1'b0, 3'b011, 1'b1, 1'b0, "R3 T2 hold");
        step(3'd3, 1'b0, 3'b000, 1'b1, 1'b0, "R4 R7 T3 ready");
        step(3'd5, 1'b0, 3'b000, 1'b1, 1'b0, "R5 T4 after");

        // R4: wait states
        step(3'd5, 1'b1, 3'b110, 1'b1, 1'b0, "R2 T4 launch");
        step(3'd1, 1'b0, 3'b110, 1'b0, 1'b0, "R3 T1");
        step(3'd2, 1'b0, 3'b110, 1'b0, 1'b0, "R3 T2");
        step(3'd3, 1'b0, 3'b110, 1'b0, 1'b0, "R4 T3 not ready");
        step(3'd4, 1'b0, 3'b110, 1'b0, 1'b0, "R4 TW not ready");
        step(3'd4, 1'b0, 3'b110, 1'b1, 1'b0, "R4 R7 TW ready");
        step(3'd5, 1'b0, 3'b110, 1'b1, 1'b0, "R5 T4");

        // R1: every kind, back to back
        for (int k = 0; k < 7; k++) begin
            step(3'd5, 1'b1, 3'(k), 1'b1, 1'b0, "R1 R6 launch");
            step(3'd1, 1'b0, 3'b111, 1'b1, 1'b0, "R1 T1");
            step(3'd2, 1'b0, 3'b111, 1'b1, 1'b0, "R1 T2");
            step(3'd3, 1'b0, 3'b111, 1'b1, 1'b0, "R1 R7 T3");
        end
        step(3'd0, 1'b0, 3'b000, 1'b1, 1'b0, "R5 idle");

        // R8: grant abandons an open cycle
        step(3'd0, 1'b1, 3'b100, 1'b1, 1'b0, "R2 launch");
        step(3'd1, 1'b0, 3'b100, 1'b1, 1'b1, "R8 grant");
        step(3'd2, 1'b0, 3'b100, 1'b1, 1'b0, "R8 abandoned");
        step(3'd3, 1'b0, 3'b100, 1'b0, 1'b0, "R8 abandoned T3");
        step(3'd5, 1'b1, 3'b101, 1'b1, 1'b1, "R8 grant T4");
        step(3'd1, 1'b0, 3'b101, 1'b1, 1'b0, "R8 no launch");
        step(3'd0, 1'b1, 3'b001, 1'b1, 1'b0, "R6 after grant");
        step(3'd1, 1'b0, 3'b001, 1'b1, 1'b0, "R3 T1");

        @(posedge clk);
        #6;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule